// File: doc/BRIEF.md
# Edge-Gated Low-Resolution Mismatch Array

This block is a square grid of comparison elements, one per pixel of an N-by-N image block. Each element stores a 2-bit quantized pixel of the current block and a 2-bit quantized pixel of a candidate reference block. It raises a flag when the two stored values differ, but only when that pixel's edge-mask bit is set. The output is one flag per pixel. A later stage can count these flags to rank candidate positions.

Current-block pixels and their mask bits enter one at a time through a single serial chain. The chain runs along each row and continues from the last element of a row into the first element of the next row, so a full load takes N*N strobes. Reference pixels enter one row per strobe, with N pixels side by side, and existing rows move down by one position on each strobe. The two load paths are independent. The current block can stay resident while reference rows stream past. Every flag is registered. The design has no state machine: its only sequencing is the two load strobes.

Top module: `edge_mismatch_array`

## Requirements
- R1: While `rst_n` is low, every stored value, every mask bit and every bit of `miss_vec` is zero.
- R2: On a clock edge with `cur_shift` high, element 0 takes `cur_pix` and `cur_mask`. Every element k>0 takes the value and mask of element k-1, where k = row*N + col. This includes the step from the last column of one row to column 0 of the next row.
- R3: The mask bit moves through the chain in the same cycle as its pixel value, so the two always stay paired.
- R4: On a clock edge with `cur_shift` low, no stored current value or mask bit changes, whatever `cur_pix` and `cur_mask` carry.
- R5: On a clock edge with `ref_load` high, row 0 takes `ref_row`, with column c taken from bits [2c+1:2c]. Every row r>0 takes the previous contents of row r-1.
- R6: On a clock edge with `ref_load` low, no stored reference value changes, whatever `ref_row` carries.
- R7: One clock edge after the stored values settle, `miss_vec[k]` is 1 exactly when element k's mask bit is 1 and its stored current value differs from its stored reference value.
- R8: An element whose mask bit is 0 drives 0, whatever its stored values are. An all-zero mask therefore gives an all-zero `miss_vec`.
- R9: A difference in either bit of the 2-bit values counts as a mismatch. This includes the pairs that differ only in bit 0, only in bit 1, or in both.
- R10: `cur_shift` and `ref_load` may be high in the same cycle, and each path then behaves as in R2 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_shift | input | 1 | Shift strobe for the current-block chain |
| cur_pix | input | 2 | Quantized current pixel entering the chain |
| cur_mask | input | 1 | Edge-mask bit paired with `cur_pix` |
| ref_load | input | 1 | Row strobe for the reference store |
| ref_row | input | 2*N | One row of quantized reference pixels, column c at bits [2c+1:2c] |
| miss_vec | output | N*N | Registered mismatch flags, bit k = row*N + col |

## Verification
The serial path is the hardest part to see from the ports. A fault at a row boundary, or a mask bit that drifts one place away from its pixel, still produces a plausible pattern once the array is full. To expose such faults, the bench first fills both stores with patterns that cover every current/reference pair. It then applies one extra shift and checks every flag against a model whose contents have all moved by one place. Idle cycles with changing data on the inputs then show that the strobes gate all storage.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
    localparam int PIX_W = 2;
    typedef logic [PIX_W-1:0] qpix_t;
endpackage

// File: rtl/mpc_cur_chain.sv
module mpc_cur_chain
    import mpc_pkg::*;
#(
    parameter int N_PIX = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   shift_en,
    input  qpix_t                  pix_in,
    input  logic                   mask_in,
    output logic [N_PIX*PIX_W-1:0] pix_vec,
    output logic [N_PIX-1:0]       mask_vec
);
    for (genvar k = 0; k < N_PIX; k++) begin : g_link
        qpix_t nxt_pix;
        logic  nxt_mask;
        if (k == 0) begin : g_head
            assign nxt_pix  = pix_in;
            assign nxt_mask = mask_in;
        end else begin : g_body
            assign nxt_pix  = pix_vec[(k-1)*PIX_W +: PIX_W];
            assign nxt_mask = mask_vec[k-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pix_vec[k*PIX_W +: PIX_W] <= '0;
                mask_vec[k]               <= 1'b0;
            end else if (shift_en) begin
                pix_vec[k*PIX_W +: PIX_W] <= nxt_pix;
                mask_vec[k]               <= nxt_mask;
            end
        end
    end
endmodule

// File: rtl/mpc_ref_rows.sv
module mpc_ref_rows
    import mpc_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_en,
    input  logic [N*PIX_W-1:0]       row_in,
    output logic [N*N*PIX_W-1:0]     ref_vec
);
    localparam int ROW_W = N * PIX_W;

    for (genvar r = 0; r < N; r++) begin : g_row
        logic [ROW_W-1:0] nxt_row;
        if (r == 0) begin : g_top
            assign nxt_row = row_in;
        end else begin : g_lower
            assign nxt_row = ref_vec[(r-1)*ROW_W +: ROW_W];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ref_vec[r*ROW_W +: ROW_W] <= '0;
            else if (load_en) ref_vec[r*ROW_W +: ROW_W] <= nxt_row;
        end
    end
endmodule

// File: rtl/mpc_cmp_cell.sv
module mpc_cmp_cell
    import mpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  qpix_t cur,
    input  qpix_t refp,
    input  logic  mask,
    output logic  miss
);
    logic differ;

    assign differ = |(cur ^ refp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) miss <= 1'b0;
        else        miss <= mask & differ;
    end

    // R8
    quiet_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask || cur == refp) |=> !miss);
    // R9
    diff_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && cur != refp) |=> miss);
endmodule

// File: rtl/edge_mismatch_array.sv
module edge_mismatch_array
    import mpc_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cur_shift,
    input  logic [PIX_W-1:0]     cur_pix,
    input  logic                 cur_mask,
    input  logic                 ref_load,
    input  logic [N*PIX_W-1:0]   ref_row,
    output logic [N*N-1:0]       miss_vec
);
    localparam int NN = N * N;

    logic [NN*PIX_W-1:0] cur_vec;
    logic [NN-1:0]       mask_vec;
    logic [NN*PIX_W-1:0] ref_vec;

    mpc_cur_chain #(.N_PIX(NN)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cur_shift),
        .pix_in   (cur_pix),
        .mask_in  (cur_mask),
        .pix_vec  (cur_vec),
        .mask_vec (mask_vec)
    );

    mpc_ref_rows #(.N(N)) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (ref_load),
        .row_in  (ref_row),
        .ref_vec (ref_vec)
    );

    for (genvar k = 0; k < NN; k++) begin : g_cell
        mpc_cmp_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .cur   (cur_vec[k*PIX_W +: PIX_W]),
            .refp  (ref_vec[k*PIX_W +: PIX_W]),
            .mask  (mask_vec[k]),
            .miss  (miss_vec[k])
        );
    end

    // R2
    head_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_shift |=> (cur_vec[PIX_W-1:0] == $past(cur_pix)) && (mask_vec[0] == $past(cur_mask)));
    // R4
    cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_shift |=> $stable(cur_vec) && $stable(mask_vec));
    // R5
    ref_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_load |=> ref_vec[N*PIX_W-1:0] == $past(ref_row));
    // R6
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_load |=> $stable(ref_vec));
endmodule

// File: tb/edge_mismatch_array_test.sv
module edge_mismatch_array_test;
    localparam int N  = 4;
    localparam int NN = N * N;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cur_shift = 1'b0;
    logic [1:0]     cur_pix = '0;
    logic           cur_mask = 1'b0;
    logic           ref_load = 1'b0;
    logic [2*N-1:0] ref_row = '0;
    logic [NN-1:0]  miss_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int ecur [NN];
    int emask[NN];
    int eref [NN];

    always #10 clk = ~clk;

    edge_mismatch_array #(.N(N)) uut (
        .clk(clk), .rst_n(rst_n), .cur_shift(cur_shift), .cur_pix(cur_pix),
        .cur_mask(cur_mask), .ref_load(ref_load), .ref_row(ref_row), .miss_vec(miss_vec)
    );

    task automatic chk(input logic got, input logic exp, input string req, input int idx);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s bit %0d: got %0b expected %0b", req, idx, got, exp);
        end
    endtask

    // One cycle of stimulus, applied at a negedge; the model follows R2/R3/R5.
    task automatic step(input bit sh, input int cp, input int cm, input bit rl, input int rv[N]);
        cur_shift = sh; cur_pix = 2'(cp); cur_mask = cm[0];
        ref_load = rl;
        for (int c = 0; c < N; c++) ref_row[2*c +: 2] = 2'(rv[c]);
        @(negedge clk);
        if (sh) begin
            for (int k = NN-1; k > 0; k--) begin ecur[k] = ecur[k-1]; emask[k] = emask[k-1]; end
            ecur[0] = cp; emask[0] = cm;
        end
        if (rl) begin
            for (int k = NN-1; k >= N; k--) eref[k] = eref[k-N];
            for (int c = 0; c < N; c++) eref[c] = rv[c];
        end
        cur_shift = 1'b0; ref_load = 1'b0;
    endtask

    task automatic check_all(input string req);
        int zr[N];
        for (int c = 0; c < N; c++) zr[c] = 0;
        step(1'b0, 0, 0, 1'b0, zr);
        for (int k = 0; k < NN; k++)
            chk(miss_vec[k], (emask[k] != 0) && (ecur[k] != eref[k]), req, k);
    endtask

    // Full load of both stores, R10 concurrency during the first N cycles.
    task automatic load_all(input int t);
        for (int s = 0; s < NN; s++) begin
            int k = NN - 1 - s;
            int cv, mv, rv[N];
            bit rl;
            cv = (t == 3) ? (k / N) % 4 : k % 4;
            case (t)
                0: mv = 1;
                1: mv = 0;
                2: mv = k % 2;
                default: mv = (k / 3) % 2;
            endcase
            rl = (s < N);
            for (int c = 0; c < N; c++) begin
                int kk = (N - 1 - s) * N + c;
                rv[c] = (t == 3) ? kk % 4 : (kk / N) % 4;
            end
            step(1'b1, cv, mv, rl, rv);
        end
    endtask

    initial begin
        for (int k = 0; k < NN; k++) begin ecur[k] = 0; emask[k] = 0; eref[k] = 0; end
        repeat (3) @(negedge clk);
        // R1: outputs zero in reset
        for (int k = 0; k < NN; k++) chk(miss_vec[k], 1'b0, "R1", k);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
        for (int t = 0; t < 4; t++) begin
            load_all(t);
            // R7/R9 all pairs (t0,t3), R8 zero mask (t1), R3 mask pairing (t2,t3), R10 concurrent
            case (t)
                0: check_all("R9");
                1: check_all("R8");
                2: check_all("R3");
                default: check_all("R10");
            endcase
            begin
                int junk[N];
                for (int c = 0; c < N; c++) junk[c] = (c + t + 1) % 4;
                // R4/R6: strobes low, data toggling
                step(1'b0, 3 - t, 1, 1'b0, junk);
                step(1'b0, t, 1, 1'b0, junk);
                check_all("R4");
                check_all("R6");
                // R2: one extra shift moves every element incl. row tails
                step(1'b1, (t + 2) % 4, 1, 1'b0, junk);
                check_all("R2");
                // R5: one extra row pushes every row down
                step(1'b0, 0, 0, 1'b1, junk);
                check_all("R5");
                check_all("R7");
            end
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule